// File: doc/BRIEF.md
# Circular Floating-Point Register Stack

This block holds eight 64-bit floating-point entries that software addresses as a stack. A 3-bit top pointer rotates around the physical entries. Stack register ST(i) resolves to physical entry (top + i) mod 8. Each entry carries an occupancy tag. Faults come from that tag, not from a depth count. A read or a read-modify-write of an empty entry raises an empty fault. A pure write to an occupied entry raises a full fault. The stored values are opaque. The block does no arithmetic, no rounding and no condition-code work.

One operation is accepted per clock while `op_valid` is high. The read result, the fault pulse, the tag word and the top pointer are all registered. They are visible after the clock edge that accepted the operation.

Two flags exempt an operation from the fault rules:
- `exam_ok` lets a read inspect any entry, empty or not.
- `copy_st0` turns a write into a copy of ST(0) that may overwrite an occupied entry.

A faulting operation leaves every entry, tag and the top pointer untouched.

Top module: `fp_stack_file`

## Requirements
- R1: After reset every tag is 0 (empty), the top pointer is 0, and `fault` and `rd_valid` are 0.
- R2: Push (op code 0) targets physical entry (top-1) mod 8.
  - If that entry is empty, the top pointer becomes (top-1) mod 8, the entry takes `wr_data` and its tag is set.
  - If that entry is occupied, a full fault is raised instead.
- R3: Pop (op code 1) handles physical entry top.
  - If that entry is occupied, it returns the entry on `rd_data` with `rd_valid`, clears its tag and sets the top pointer to (top+1) mod 8.
  - If that entry is empty, an empty fault is raised instead.
- R4: Read (op code 2), write (op code 3) and modify (op code 4) address physical entry (top + `st_idx`) mod 8, wrapping past entry 7 to entry 0.
- R5: Read of an occupied entry returns its value with `rd_valid` and changes no state. Read of an empty entry with `exam_ok` low raises an empty fault.
- R6: Write with `copy_st0` low stores `wr_data` into an empty target and sets its tag. If the target is occupied it raises a full fault.
- R7: Modify of an occupied target returns the old value on `rd_data` and stores `wr_data`. Modify of an empty target raises an empty fault.
- R8: Read with `exam_ok` high never faults, even on an empty entry. It raises `rd_valid` and changes no tag.
- R9: Write with `copy_st0` high copies ST(0) into the target and sets the target's tag.
  - It raises no full fault even when the target is occupied.
  - If ST(0) is empty it raises an empty fault.
- R10: An operation that faults changes no entry, no tag and not the top pointer, and it does not raise `rd_valid`.
- R11: Set-top (op code 5) loads the top pointer from `wr_data[2:0]`. All higher bits of `wr_data` are ignored.
- R12: `fault` is a pulse lasting one cycle per faulting operation. `fault_kind` is 0 for an empty fault and 1 for a full fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation accepted this cycle |
| op_code | input | 3 | 0 push, 1 pop, 2 read, 3 write, 4 modify, 5 set-top, 6-7 no operation |
| st_idx | input | 3 | Stack-relative index i of ST(i) |
| wr_data | input | 64 | Value for push, write and modify; new top for set-top |
| exam_ok | input | 1 | Read exempt from the empty fault |
| copy_st0 | input | 1 | Write copies ST(0) and is exempt from the full fault |
| rd_valid | output | 1 | `rd_data` holds a result of the last operation |
| rd_data | output | 64 | Value read by read, pop or modify |
| fault | output | 1 | One-cycle fault pulse |
| fault_kind | output | 1 | 0 empty fault, 1 full fault |
| tag_word | output | 8 | Bit k is the occupancy tag of physical entry k |
| top_ptr | output | 3 | Current top pointer |

## Verification
The assertions assume that `op_code`, `st_idx` and both exemption flags are stable and known whenever `op_valid` is high. They also assume the flags matter only for read and write. The stimulus respects this:
- It changes inputs only on the falling edge.
- It drops `op_valid` between operations.
- It raises `exam_ok` only on reads and `copy_st0` only on writes.

The corner cases covered are wrap of ST(i) past entry 7 and a top pointer moved by set-top with junk upper bits.

// File: rtl/fp_stack_file.sv
module fp_stack_file #(
  parameter int DW    = 64,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       op_valid,
  input  logic [2:0]                 op_code,
  input  logic [$clog2(DEPTH)-1:0]   st_idx,
  input  logic [DW-1:0]              wr_data,
  input  logic                       exam_ok,
  input  logic                       copy_st0,
  output logic                       rd_valid,
  output logic [DW-1:0]              rd_data,
  output logic                       fault,
  output logic                       fault_kind,
  output logic [DEPTH-1:0]           tag_word,
  output logic [$clog2(DEPTH)-1:0]   top_ptr
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW-1:0] ONE = PW'(1);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_READ = 3'd2,
                         OP_WRITE = 3'd3, OP_MOD = 3'd4, OP_TOP = 3'd5;

  logic [DW-1:0]    ent_q [DEPTH];
  logic [DEPTH-1:0] tag_q;
  logic [PW-1:0]    top_q;

  wire is_push = op_valid && op_code == OP_PUSH;
  wire is_pop  = op_valid && op_code == OP_POP;
  wire is_rd   = op_valid && op_code == OP_READ;
  wire is_wr   = op_valid && op_code == OP_WRITE;
  wire is_mod  = op_valid && op_code == OP_MOD;
  wire is_top  = op_valid && op_code == OP_TOP;

  wire [PW-1:0] down_slot = top_q - ONE;
  wire [PW-1:0] up_slot   = top_q + ONE;
  wire [PW-1:0] rel_slot  = top_q + st_idx;
  wire [PW-1:0] sel       = is_push ? down_slot : (is_pop ? top_q : rel_slot);
  wire          sel_full  = tag_q[sel];
  wire          st0_full  = tag_q[top_q];

  wire f_empty = ((is_pop || is_mod) && !sel_full)
              || (is_rd && !exam_ok && !sel_full)
              || (is_wr && copy_st0 && !st0_full);
  wire f_full  = (is_push && sel_full) || (is_wr && !copy_st0 && sel_full);
  wire f_any   = f_empty || f_full;

  wire          do_store = !f_any && (is_push || is_wr || is_mod);
  wire          do_clear = !f_any && is_pop;
  wire [DW-1:0] store_val = (is_wr && copy_st0) ? ent_q[top_q] : wr_data;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_q[k] <= '0;
        tag_q[k] <= 1'b0;
      end else if (do_store && sel == PW'(k)) begin
        ent_q[k] <= store_val;
        tag_q[k] <= 1'b1;
      end else if (do_clear && sel == PW'(k)) begin
        tag_q[k] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top_q      <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      fault      <= 1'b0;
      fault_kind <= 1'b0;
    end else begin
      fault      <= f_any;
      fault_kind <= f_full && !f_empty;
      rd_valid   <= !f_any && (is_rd || is_pop || is_mod);
      if (!f_any && (is_rd || is_pop || is_mod))
        rd_data <= ent_q[sel];
      if (!f_any) begin
        if (is_push)     top_q <= down_slot;
        else if (is_pop) top_q <= up_slot;
        else if (is_top) top_q <= wr_data[PW-1:0];
      end
    end
  end

  assign tag_word = tag_q;
  assign top_ptr  = top_q;

  // R2
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_PUSH && !tag_q[top_q - ONE])
      |=> (top_ptr == $past(top_q) - ONE) && tag_word[top_ptr]);

  // R3
  pop_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_POP && tag_q[top_q])
      |=> !tag_word[$past(top_q)] && rd_valid);

  // R8
  exam_nofault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_READ && exam_ok) |=> !fault && rd_valid);

  // R9
  copy_nofull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_WRITE && copy_st0 && tag_q[top_q]) |=> !fault);

  // R10
  fault_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $stable(tag_word) && $stable(top_ptr) && !rd_valid);

  // R12
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !$past(op_valid)) |-> 1'b0);
endmodule

// File: tb/fp_stack_file_bench.sv
`timescale 1ns/1ps
module fp_stack_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [2:0]  st_idx = '0;
  logic [63:0] wr_data = '0;
  logic        exam_ok = 1'b0;
  logic        copy_st0 = 1'b0;
  logic        rd_valid, fault, fault_kind;
  logic [63:0] rd_data;
  logic [7:0]  tag_word;
  logic [2:0]  top_ptr;
  int          n_chk = 0;
  int          n_bad = 0;

  localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
  localparam logic [63:0] VB = 64'hBBBB_0000_CCCC_0001;
  localparam logic [63:0] VC = 64'hC0DE_C0DE_0000_FFFF;
  localparam logic [63:0] VD = 64'hDDDD_1234_5678_9ABC;
  localparam logic [63:0] VE = 64'hEEEE_EEEE_0000_0005;

  always #4 clk = ~clk;

  fp_stack_file u_fp_stack_file (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .st_idx(st_idx), .wr_data(wr_data), .exam_ok(exam_ok), .copy_st0(copy_st0),
    .rd_valid(rd_valid), .rd_data(rd_data), .fault(fault), .fault_kind(fault_kind),
    .tag_word(tag_word), .top_ptr(top_ptr));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] code, input logic [2:0] idx,
                        input logic [63:0] data, input logic ex, input logic cp);
    @(negedge clk);
    op_valid = 1'b1; op_code = code; st_idx = idx; wr_data = data;
    exam_ok = ex; copy_st0 = cp;
    @(negedge clk);
    op_valid = 1'b0; exam_ok = 1'b0; copy_st0 = 1'b0;
  endtask

  task automatic expect_ok(input string req, input logic rv, input logic [63:0] rdv);
    chk(req, {63'd0, fault}, 64'd0);
    chk(req, {63'd0, rd_valid}, {63'd0, rv});
    if (rv) chk(req, rd_data, rdv);
  endtask

  task automatic expect_fault(input string req, input logic kind);
    chk(req, {63'd0, fault}, 64'd1);
    chk(req, {63'd0, fault_kind}, {63'd0, kind});
    chk(req, {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 tags", {56'd0, tag_word}, 64'd0);
    chk("R1 top", {61'd0, top_ptr}, 64'd0);
    chk("R1 fault", {63'd0, fault}, 64'd0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic t_push;
    run_op(3'd0, 3'd0, VA, 1'b0, 1'b0);
    expect_ok("R2 push A", 1'b0, '0);
    chk("R2 top after A", {61'd0, top_ptr}, 64'd7);
    chk("R2 tags after A", {56'd0, tag_word}, 64'h80);
    run_op(3'd0, 3'd0, VB, 1'b0, 1'b0);
    run_op(3'd0, 3'd0, VC, 1'b0, 1'b0);
    chk("R2 top after C", {61'd0, top_ptr}, 64'd5);
    chk("R2 tags after C", {56'd0, tag_word}, 64'hE0);
  endtask

  task automatic t_index;
    run_op(3'd2, 3'd0, '0, 1'b0, 1'b0);
    expect_ok("R4 R5 read ST0", 1'b1, VC);
    run_op(3'd2, 3'd2, '0, 1'b0, 1'b0);
    expect_ok("R4 read ST2", 1'b1, VA);
    run_op(3'd2, 3'd3, '0, 1'b0, 1'b0);
    expect_fault("R5 read empty wrapped", 1'b0);
    @(negedge clk);
    chk("R12 fault pulse ends", {63'd0, fault}, 64'd0);
    chk("R10 tags after read fault", {56'd0, tag_word}, 64'hE0);
  endtask

  task automatic t_pop;
    run_op(3'd1, 3'd0, '0, 1'b0, 1'b0);
    expect_ok("R3 pop", 1'b1, VC);
    chk("R3 top", {61'd0, top_ptr}, 64'd6);
    chk("R3 tags", {56'd0, tag_word}, 64'hC0);
  endtask

  task automatic t_settop;
    run_op(3'd5, 3'd0, 64'hABCD_0000_0000_00FA, 1'b0, 1'b0);
    chk("R11 top from low bits", {61'd0, top_ptr}, 64'd2);
    run_op(3'd2, 3'd5, '0, 1'b0, 1'b0);
    expect_ok("R4 wrap ST5", 1'b1, VA);
    run_op(3'd2, 3'd4, '0, 1'b0, 1'b0);
    expect_ok("R4 wrap ST4", 1'b1, VB);
  endtask

  task automatic t_write;
    run_op(3'd3, 3'd1, VD, 1'b0, 1'b0);
    expect_ok("R6 write empty", 1'b0, '0);
    chk("R6 tags", {56'd0, tag_word}, 64'hC8);
    run_op(3'd2, 3'd1, '0, 1'b0, 1'b0);
    expect_ok("R6 readback", 1'b1, VD);
    run_op(3'd3, 3'd1, VE, 1'b0, 1'b0);
    expect_fault("R6 write full", 1'b1);
    chk("R10 top after write fault", {61'd0, top_ptr}, 64'd2);
    run_op(3'd2, 3'd1, '0, 1'b0, 1'b0);
    expect_ok("R10 data kept", 1'b1, VD);
  endtask

  task automatic t_modify;
    run_op(3'd4, 3'd1, VE, 1'b0, 1'b0);
    expect_ok("R7 modify old", 1'b1, VD);
    run_op(3'd2, 3'd1, '0, 1'b0, 1'b0);
    expect_ok("R7 modify new", 1'b1, VE);
    run_op(3'd4, 3'd0, VA, 1'b0, 1'b0);
    expect_fault("R7 modify empty", 1'b0);
    chk("R10 tags after modify fault", {56'd0, tag_word}, 64'hC8);
  endtask

  task automatic t_examine;
    run_op(3'd2, 3'd0, '0, 1'b1, 1'b0);
    chk("R8 no fault", {63'd0, fault}, 64'd0);
    chk("R8 rd_valid", {63'd0, rd_valid}, 64'd1);
    chk("R8 tags", {56'd0, tag_word}, 64'hC8);
    run_op(3'd2, 3'd0, '0, 1'b0, 1'b0);
    expect_fault("R5 same read without exemption", 1'b0);
  endtask

  task automatic t_copy;
    run_op(3'd3, 3'd1, VA, 1'b0, 1'b1);
    expect_fault("R9 copy empty ST0", 1'b0);
    run_op(3'd2, 3'd1, '0, 1'b0, 1'b0);
    expect_ok("R10 target kept", 1'b1, VE);
    run_op(3'd5, 3'd0, 64'd3, 1'b0, 1'b0);
    run_op(3'd3, 3'd3, VA, 1'b0, 1'b1);
    expect_ok("R9 copy onto full", 1'b0, '0);
    run_op(3'd2, 3'd3, '0, 1'b0, 1'b0);
    expect_ok("R9 copied value", 1'b1, VE);
    chk("R9 tags", {56'd0, tag_word}, 64'hC8);
  endtask

  task automatic t_edge_faults;
    run_op(3'd5, 3'd0, 64'd4, 1'b0, 1'b0);
    run_op(3'd0, 3'd0, VA, 1'b0, 1'b0);
    expect_fault("R2 push onto full", 1'b1);
    chk("R10 top after push fault", {61'd0, top_ptr}, 64'd4);
    run_op(3'd2, 3'd7, '0, 1'b0, 1'b0);
    expect_ok("R10 entry kept", 1'b1, VE);
    run_op(3'd5, 3'd0, 64'd2, 1'b0, 1'b0);
    run_op(3'd1, 3'd0, '0, 1'b0, 1'b0);
    expect_fault("R3 pop empty", 1'b0);
    chk("R10 top after pop fault", {61'd0, top_ptr}, 64'd2);
    chk("R10 tags after pop fault", {56'd0, tag_word}, 64'hC8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push();
    t_index();
    t_pop();
    t_settop();
    t_write();
    t_modify();
    t_examine();
    t_copy();
    t_edge_faults();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule